// File: doc/BRIEF.md
# Queued Video Pixel Streamer

This block turns short descriptions of video line segments into a continuous pixel stream. A controller hands it one frame at a time. A frame is a 32-bit colour word holding four byte-wide colours, a 32-bit pixel word holding sixteen 2-bit pixel codes, and a timing word. The timing word sets the length of the frame in output clocks and the number of output clocks each pixel lasts. Each pixel code chooses one of the four colour bytes. That byte drives an 8-bit output group, and a 2-bit select places the group on one byte lane of a 32-bit output port.

The horizontal and vertical sync levels are not separate outputs. They are bits inside the colour bytes, so a porch or a sync pulse is a frame whose palette carries the right sync pattern. The block holds one frame in a single-entry slot while the current frame streams. The slot entry starts on the clock right after the current frame's last clock, so segments join with no gap. If the slot is empty when a frame ends, streaming does not pause. It restarts from the values currently on the colour and pixel inputs and keeps the last timing. Software must therefore keep the slot fed, and must make the frame lengths of each line add up to the same total.

Top module: `pxs_stream`

## Requirements
- R1: The timing word `ld_timing[11:0]` gives the frame length in output clocks. `ld_timing[19:12]` gives the pixel length: the number of consecutive output clocks each pixel code is held.
- R2: Once streaming has begun, output never stops. A frame waiting in the slot becomes active on the clock directly after the last clock of the current frame.
- R3: A pixel code c (0..3) selects colour byte c of the frame's colour word, bits [8c+7:8c]. Code 0 selects bits [7:0] and code 3 selects bits [31:24].
- R4: Pixel codes are used from the pixel word's least significant pair upward, bits [1:0] first, sixteen per word. A frame longer than sixteen pixels wraps back to bits [1:0].
- R5: The selected byte appears on `vid_out[8s+7:8s]`, where s is `lane_sel`. The other three lanes read zero.
- R6: `ld_ready` is high exactly when the slot is empty. A load accepted while ready makes `ld_ready` low on the next cycle. `ld_ready` goes high again in the first clock of that frame's streaming.
- R7: If a frame ends with the slot empty, the next frame takes its colour and pixel words from the live `ld_color`/`ld_pixels` inputs and reuses the previous timing word.
- R8: A pixel length of 0 acts as 1. A frame length of 0 acts as 4096.
- R9: After reset, `vid_out` is zero and `ld_ready` is high, and nothing streams until the first load. A load accepted at clock edge E starts streaming after edge E+1.
- R10: Colour bytes reach the lane bit for bit, so sync is coded inside the palette. In a sync-only palette, code 0 = 0x03 (both syncs idle high on bits 1 and 0) and code 1 = 0x01 (horizontal sync on bit 1 active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output (pixel) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe for a new frame |
| ld_ready | output | 1 | Slot empty; a load is accepted this cycle |
| ld_color | input | 32 | Four colour bytes; also sampled live on unfed restarts |
| ld_pixels | input | 32 | Sixteen 2-bit pixel codes; also sampled live on unfed restarts |
| ld_timing | input | 20 | [11:0] frame clocks, [19:12] clocks per pixel |
| lane_sel | input | 2 | Byte lane that carries the output group |
| vid_out | output | 32 | Output port, one active byte lane |

## Verification
An accepted load reaches the output two edges later when the block is idle. Otherwise it starts one edge after the current frame's last clock. In both cases `ld_ready` rises at the same edge the frame starts. The bench therefore waits for `ld_ready` to return high and treats that falling-edge sample as output clock 0 of the frame. It then predicts every later falling-edge sample from the clock index, the pixel length and the palette. `ld_ready` is checked one edge after each accepted load. Unfed restarts and the 4096-clock default length are checked at the exact clock index where the next frame's data first appears.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned CODE_W = 2;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned FCLK_W = 12;
  parameter int unsigned PCLK_W = 8;

  localparam int unsigned TIME_W  = FCLK_W + PCLK_W;
  localparam int unsigned FCNT_W  = FCLK_W + 1;
  localparam int unsigned NLANES  = WORD_W / BYTE_W;
  localparam int unsigned LSEL_W  = $clog2(NLANES);

  typedef struct packed {
    logic [WORD_W-1:0] color;
    logic [WORD_W-1:0] pixels;
    logic [TIME_W-1:0] timing;
  } frame_t;

  // Frame length in clocks; zero field means the full 2**FCLK_W span.
  function automatic logic [FCNT_W-1:0] frame_len(input logic [TIME_W-1:0] t);
    if (t[FCLK_W-1:0] == '0) return {1'b1, {FCLK_W{1'b0}}};
    return {1'b0, t[FCLK_W-1:0]};
  endfunction

  // Clocks per pixel; zero field behaves as one.
  function automatic logic [PCLK_W-1:0] pix_len(input logic [TIME_W-1:0] t);
    if (t[TIME_W-1:FCLK_W] == '0) return {{(PCLK_W-1){1'b0}}, 1'b1};
    return t[TIME_W-1:FCLK_W];
  endfunction

  // Move to the next pixel code, recycling the used pair at the top.
  function automatic logic [WORD_W-1:0] next_pixels(input logic [WORD_W-1:0] p);
    return {p[CODE_W-1:0], p[WORD_W-1:CODE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] palette_pick(input logic [WORD_W-1:0] c,
                                                     input logic [CODE_W-1:0] code);
    return c[code*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/pxs_slot.sv
module pxs_slot
  import pxs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ld_valid,
  input  frame_t ld_frame,
  input  logic   take,
  output logic   full,
  output frame_t q_frame
);
  logic accept;
  assign accept = ld_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      q_frame <= '0;
    end else if (accept) begin
      full    <= 1'b1;
      q_frame <= ld_frame;
    end else if (take) begin
      full    <= 1'b0;
    end
  end
endmodule

// File: rtl/pxs_engine.sv
module pxs_engine
  import pxs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q_full,
  input  frame_t             q_frame,
  input  logic [WORD_W-1:0]  bus_color,
  input  logic [WORD_W-1:0]  bus_pixels,
  output logic               take,
  output logic               running,
  output logic               frame_last,
  output logic               pix_adv,
  output logic [WORD_W-1:0]  cur_color,
  output logic [CODE_W-1:0]  cur_code
);
  logic [WORD_W-1:0] pix_q;
  logic [TIME_W-1:0] tim_q;
  logic [FCNT_W-1:0] fcnt_q;
  logic [PCLK_W-1:0] pcnt_q;
  logic              reload_bus;

  assign frame_last = running && (fcnt_q == FCNT_W'(1));
  assign pix_adv    = running && (pcnt_q == PCLK_W'(1)) && !frame_last;
  assign take       = q_full && (!running || frame_last);
  assign reload_bus = frame_last && !q_full;
  assign cur_code   = pix_q[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cur_color <= '0;
      pix_q     <= '0;
      tim_q     <= '0;
      fcnt_q    <= '0;
      pcnt_q    <= '0;
    end else if (take) begin
      running   <= 1'b1;
      cur_color <= q_frame.color;
      pix_q     <= q_frame.pixels;
      tim_q     <= q_frame.timing;
      fcnt_q    <= frame_len(q_frame.timing);
      pcnt_q    <= pix_len(q_frame.timing);
    end else if (reload_bus) begin
      cur_color <= bus_color;
      pix_q     <= bus_pixels;
      fcnt_q    <= frame_len(tim_q);
      pcnt_q    <= pix_len(tim_q);
    end else if (running) begin
      fcnt_q <= fcnt_q - FCNT_W'(1);
      if (pix_adv) begin
        pix_q  <= next_pixels(pix_q);
        pcnt_q <= pix_len(tim_q);
      end else begin
        pcnt_q <= pcnt_q - PCLK_W'(1);
      end
    end
  end
endmodule

// File: rtl/pxs_lanes.sv
module pxs_lanes
  import pxs_pkg::*;
(
  input  logic               running,
  input  logic [WORD_W-1:0]  cur_color,
  input  logic [CODE_W-1:0]  cur_code,
  input  logic [LSEL_W-1:0]  lane_sel,
  output logic [WORD_W-1:0]  vid_out
);
  logic [BYTE_W-1:0] group;
  assign group = palette_pick(cur_color, cur_code);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign vid_out[g*BYTE_W +: BYTE_W] =
      (running && lane_sel == LSEL_W'(g)) ? group : '0;
  end
endmodule

// File: rtl/pxs_stream.sv
module pxs_stream
  import pxs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  output logic                   ld_ready,
  input  logic [WORD_W-1:0]      ld_color,
  input  logic [WORD_W-1:0]      ld_pixels,
  input  logic [TIME_W-1:0]      ld_timing,
  input  logic [LSEL_W-1:0]      lane_sel,
  output logic [WORD_W-1:0]      vid_out
);
  frame_t            ld_frame;
  frame_t            q_frame;
  logic              q_full;
  logic              take;
  logic              running;
  logic              frame_last;
  logic              pix_adv;
  logic [WORD_W-1:0] cur_color;
  logic [CODE_W-1:0] cur_code;

  assign ld_frame = '{color: ld_color, pixels: ld_pixels, timing: ld_timing};
  assign ld_ready = !q_full;

  pxs_slot u_slot (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_frame(ld_frame),
    .take(take), .full(q_full), .q_frame(q_frame)
  );

  pxs_engine u_engine (
    .clk(clk), .rst_n(rst_n), .q_full(q_full), .q_frame(q_frame),
    .bus_color(ld_color), .bus_pixels(ld_pixels), .take(take),
    .running(running), .frame_last(frame_last), .pix_adv(pix_adv),
    .cur_color(cur_color), .cur_code(cur_code)
  );

  pxs_lanes u_lanes (
    .running(running), .cur_color(cur_color), .cur_code(cur_code),
    .lane_sel(lane_sel), .vid_out(vid_out)
  );
endmodule

// File: rtl/pxs_stream_chk.sv
module pxs_stream_chk
  import pxs_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic               ld_ready,
  input logic               q_full,
  input logic               running,
  input logic               frame_last,
  input logic               pix_adv,
  input logic [CODE_W-1:0]  cur_code,
  input logic [WORD_W-1:0]  vid_out
);
  logic [NLANES-1:0] lane_busy;
  for (genvar g = 0; g < NLANES; g++) begin : g_busy
    assign lane_busy[g] = |vid_out[g*BYTE_W +: BYTE_W];
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_busy));                                          // R5
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> vid_out == '0);                                   // R9
  AST_NEVER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);                                          // R2
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);                         // R6
  AST_SLOT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && q_full) |=> ld_ready);                          // R2
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pix_adv && !frame_last) |=> $stable(cur_code));   // R1
  AST_READY_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready == !q_full);                                          // R6
endmodule

bind pxs_stream pxs_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .q_full(q_full), .running(running), .frame_last(frame_last),
  .pix_adv(pix_adv), .cur_code(cur_code), .vid_out(vid_out)
);

// File: tb/pxs_stream_tb.sv
module pxs_stream_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [31:0] ld_color = '0;
  logic [31:0] ld_pixels = '0;
  logic [19:0] ld_timing = '0;
  logic [1:0]  lane_sel = '0;
  logic [31:0] vid_out;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxs_stream u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_color(ld_color), .ld_pixels(ld_pixels), .ld_timing(ld_timing),
    .lane_sel(lane_sel), .vid_out(vid_out)
  );

  // Expected port value at clock k (0-based) of a frame.
  function automatic logic [31:0] expect_out(logic [31:0] c, logic [31:0] w,
                                             logic [19:0] t, logic [1:0] s, int k);
    int plen = (t[19:12] == 0) ? 1 : int'(t[19:12]);
    int idx  = (k / plen) % 16;
    int code = int'((w >> (2*idx)) & 32'h3);
    logic [7:0] b = 8'((c >> (8*code)) & 32'hFF);
    return 32'(b) << (8*s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Waits until the slot is free, loads a frame, and returns at clock 0 of it.
  task automatic start_frame(logic [31:0] c, logic [31:0] w, logic [19:0] t);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_color = c; ld_pixels = w; ld_timing = t; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    while (!ld_ready) @(negedge clk);
  endtask

  task automatic check_frame(string req, logic [31:0] c, logic [31:0] w,
                             logic [19:0] t, int n);
    for (int k = 0; k < n; k++) begin
      check(req, vid_out, expect_out(c, w, t, lane_sel, k));
      if (k != n-1) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 idle output", vid_out, 32'h0);
      check("R9 idle ready", 32'(ld_ready), 32'h1);
    end
  endtask

  task automatic t_first_start();
    // Load at edge E, first pixel after E+1.
    lane_sel = 2'd0;
    @(negedge clk);
    ld_color = 32'h44332211; ld_pixels = 32'hE4E4E4E4;
    ld_timing = {8'd1, 12'd8}; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R9 not yet streaming", vid_out, 32'h0);
    check("R6 ready low after accept", 32'(ld_ready), 32'h0);
    @(negedge clk);
    check("R9 ready back at start", 32'(ld_ready), 32'h1);
    check_frame("R3 palette select", 32'h44332211, 32'hE4E4E4E4, {8'd1, 12'd8}, 8);
  endtask

  task automatic t_pixel_len();
    lane_sel = 2'd1;
    start_frame(32'hDDCCBBAA, 32'h0000001B, {8'd3, 12'd12});
    check_frame("R1 pixel length 3", 32'hDDCCBBAA, 32'h0000001B, {8'd3, 12'd12}, 12);
  endtask

  task automatic t_wrap();
    lane_sel = 2'd0;
    start_frame(32'h0F0E0D0C, 32'h000000E4, {8'd1, 12'd20});
    check_frame("R4 pair order and wrap", 32'h0F0E0D0C, 32'h000000E4, {8'd1, 12'd20}, 20);
  endtask

  task automatic t_lane();
    lane_sel = 2'd3;
    start_frame(32'h8C8B8A89, 32'h4E4E4E4E, {8'd2, 12'd8});
    check_frame("R5 top lane only", 32'h8C8B8A89, 32'h4E4E4E4E, {8'd2, 12'd8}, 8);
  endtask

  task automatic t_queue();
    logic [31:0] ca = 32'h0C0B0A09, wa = 32'hE4E4E4E4;
    logic [31:0] cb = 32'h80706050, wb = 32'h1B1B1B1B;
    logic [19:0] ta = {8'd1, 12'd5}, tb = {8'd2, 12'd6};
    lane_sel = 2'd0;
    start_frame(ca, wa, ta);
    check("R2 frame A k0", vid_out, expect_out(ca, wa, ta, 2'd0, 0));
    ld_color = cb; ld_pixels = wb; ld_timing = tb; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R6 slot full while A streams", 32'(ld_ready), 32'h0);
    for (int k = 1; k < 5; k++) begin
      check("R2 frame A", vid_out, expect_out(ca, wa, ta, 2'd0, k));
      @(negedge clk);
    end
    check("R6 ready as B starts", 32'(ld_ready), 32'h1);
    check_frame("R2 B follows A with no gap", cb, wb, tb, 6);
  endtask

  task automatic t_continue();
    logic [31:0] c1 = 32'h13121110, w1 = 32'hE4E4E4E4;
    logic [31:0] c2 = 32'h27262524, w2 = 32'h1B1B1B1B;
    logic [19:0] t1 = {8'd1, 12'd4};
    lane_sel = 2'd2;
    start_frame(c1, w1, t1);
    ld_color = c2; ld_pixels = w2;
    check_frame("R7 fed frame", c1, w1, t1, 4);
    @(negedge clk);
    check_frame("R7 restart from live buses", c2, w2, t1, 4);
  endtask

  task automatic t_sync();
    logic [31:0] c = 32'h00000103, w = 32'h00000050;
    logic [19:0] t = {8'd2, 12'd8};
    lane_sel = 2'd2;
    start_frame(c, w, t);
    for (int k = 0; k < 8; k++) begin
      check("R10 sync bits in palette", vid_out, expect_out(c, w, t, 2'd2, k));
      check("R10 hsync bit", 32'(vid_out[17]), (k >= 4 && k < 8) ? 32'h0 : 32'h1);
      if (k != 7) @(negedge clk);
    end
  endtask

  task automatic t_zero_fields();
    logic [31:0] c = 32'h0000CCAA, w = 32'h00000001, c2 = 32'h77777777;
    lane_sel = 2'd0;
    start_frame(c, w, 20'h0);
    ld_color = c2;
    check("R8 pixel len 0 acts as 1 k0", vid_out, 32'h000000CC);
    @(negedge clk);
    check("R8 pixel len 0 acts as 1 k1", vid_out, 32'h000000AA);
    for (int k = 2; k < 4095; k++) @(negedge clk);
    @(negedge clk);
    check("R8 frame still on at clock 4095", vid_out, 32'h000000AA);
    @(negedge clk);
    check("R8 new frame at clock 4096", vid_out, 32'h00000077);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_start();
    t_pixel_len();
    t_wrap();
    t_lane();
    t_queue();
    t_continue();
    t_sync();
    t_zero_fields();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule